// File: doc/BRIEF.md
# Split Instruction/Data Line-Fill Buffer Pair

This block holds the cache line most recently requested after a miss, once for instruction fetches and once for operand fetches. A miss loads the line address into the buffer for its type and clears that buffer's word valids. The line then arrives from the bus one 32-bit word at a time, in any order. Each word sets its own valid bit. A fetch that names a word already present is answered in the same cycle, before the rest of the line has arrived.

The cache mode picks which buffers are in use. In instruction-only mode only the instruction buffer works, in data-only mode only the data buffer works, and in split mode both work. A buffer that is not in use ignores misses, fills and fetches, and keeps whatever it held. Once all words of a line are present, the buffer offers the full line to the cache array for one cycle. If the cache array also reports a hit for the fetch, the array's result takes priority and the buffer stays silent.

Top module: `lfb_pair`

## Requirements
- R1: After synchronous active-low reset, every word of both buffers is invalid, so `hit_o` stays 0 for every fetch and `wb_valid_o` is 0.
- R2: A miss accepted on the buffer of its type (`miss_instr_i` 1 = instruction, 0 = data) loads address bits [31:4] as the line address and clears all four word valids. Words held before the miss no longer hit after the clock edge that accepts the miss.
- R3: A fill word sets the valid bit of word index `fill_addr_i[3:2]` in the buffer that `fill_instr_i` selects, and stores the data there. The word hits from the cycle after that clock edge, even when the line is incomplete. Words that have not arrived do not hit.
- R4: `hit_o` is 1 only when `fetch_valid_i` is 1 and the buffer of the fetch's type is in use. Fetch address bits [31:4] must equal its line address, and the word at `fetch_addr_i[3:2]` must be valid. Bits [1:0] are ignored. `hit_data_o` carries that word in the same cycle.
- R5: While `arr_hit_i` is 1, `hit_o` is 0.
- R6: `mode_i` = 2'b00 uses only the instruction buffer, 2'b01 uses only the data buffer, and 2'b10 or 2'b11 uses both. A buffer that is not in use gives no hit. It also ignores misses and fills, and keeps the line it held.
- R7: In the cycle after the edge that makes all four words valid, `wb_valid_o` is 1 for exactly one cycle. With it come `wb_instr_o` (the buffer's type), `wb_tag_o` (line address bits [31:4]) and `wb_line_o`, which holds word k in bits [32k+31:32k].
- R8: A fill word for the same buffer in the same cycle as a miss counts toward the new line.
- R9: After completing, a buffer keeps its line and keeps hitting on it until its next accepted miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Cache mode: 00 instruction only, 01 data only, 1x split |
| miss_start_i | input | 1 | Start a new line for a miss |
| miss_instr_i | input | 1 | Miss type: 1 instruction, 0 data |
| miss_addr_i | input | 32 | Address of the missing fetch |
| fill_valid_i | input | 1 | A line word arrives from the bus |
| fill_instr_i | input | 1 | Buffer that receives the word: 1 instruction, 0 data |
| fill_addr_i | input | 32 | Address of the arriving word |
| fill_data_i | input | 32 | Arriving word |
| fetch_valid_i | input | 1 | A fetch is presented |
| fetch_instr_i | input | 1 | Fetch type: 1 instruction, 0 data |
| fetch_addr_i | input | 32 | Fetch address |
| arr_hit_i | input | 1 | Cache array hits the same fetch |
| hit_o | output | 1 | Buffer serves the fetch this cycle |
| hit_data_o | output | 32 | Word returned on a buffer hit |
| wb_valid_o | output | 1 | One-cycle request to write a complete line into the array |
| wb_instr_o | output | 1 | Type of the line being written |
| wb_tag_o | output | 28 | Line address of the line being written |
| wb_line_o | output | 128 | Complete line, word 0 in the low bits |

## Verification
One corner case is a word used in the same cycle it arrives. A design that passed arriving data straight through would hit one cycle early, and one that waited for the whole line would never give a partial hit. The bench fills words out of order and checks that the write-back strobe fires once. A level-held strobe would write the array on every cycle. The bench also checks that a miss arriving with a word counts that word. Finally, it checks that a buffer switched out by the mode keeps its old line. A design that let the disabled buffer accept misses or fills would lose the old line or hit on stray words.

// File: rtl/lfb_pkg.sv
// Shared definitions for the line-fill buffer pair.
// Assumes: side 0 is the operand (data) buffer and side 1 the instruction buffer.
package lfb_pkg;

    typedef enum logic [1:0] {
        MODE_INSTR_ONLY = 2'b00,
        MODE_DATA_ONLY  = 2'b01,
        MODE_SPLIT      = 2'b10,
        MODE_SPLIT_ALT  = 2'b11
    } lfb_mode_e;

    localparam int unsigned SIDE_DATA  = 0;
    localparam int unsigned SIDE_INSTR = 1;
    localparam int unsigned SIDES      = 2;

    // Tells whether the buffer of one side is in use under a given mode.
    function automatic logic side_in_use(input logic [1:0] mode, input logic is_instr);
        case (lfb_mode_e'(mode))
            MODE_INSTR_ONLY: side_in_use = is_instr;
            MODE_DATA_ONLY:  side_in_use = !is_instr;
            default:         side_in_use = 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/lfb_entry.sv
// One line-fill buffer: line address, per-word valids and word storage.
// Assumes the caller gates start/write with the side select; en_i removes the
// buffer from use without touching its contents.
module lfb_entry #(
    parameter int unsigned WORD_W     = 32,
    parameter int unsigned LINE_WORDS = 4,
    parameter int unsigned TAG_W      = 28,
    localparam int unsigned IDX_W     = $clog2(LINE_WORDS),
    localparam int unsigned LINE_W    = WORD_W * LINE_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              start_i,
    input  logic [TAG_W-1:0]  start_tag_i,
    input  logic              word_we_i,
    input  logic [IDX_W-1:0]  word_idx_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic [TAG_W-1:0]  probe_tag_i,
    input  logic [IDX_W-1:0]  probe_idx_i,
    output logic              probe_hit_o,
    output logic [WORD_W-1:0] probe_word_o,
    output logic              done_o,
    output logic [TAG_W-1:0]  line_tag_o,
    output logic [LINE_W-1:0] line_o
);

    logic [TAG_W-1:0]      tag_q;
    logic [LINE_WORDS-1:0] valid_q;
    logic [LINE_WORDS-1:0] valid_nxt;
    logic [WORD_W-1:0]     words_q [LINE_WORDS];
    logic                  pushed_q;
    logic                  start_ok;
    logic                  we_ok;

    assign start_ok = en_i && start_i;
    assign we_ok    = en_i && word_we_i;

    // Next valids: a new miss clears them, an arriving word sets its own bit.
    always_comb begin
        valid_nxt = start_ok ? '0 : valid_q;
        if (we_ok) begin
            valid_nxt[word_idx_i] = 1'b1;
        end
    end

    // Line address, valids and the write-back-issued flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q    <= '0;
            valid_q  <= '0;
            pushed_q <= 1'b0;
        end else begin
            valid_q <= valid_nxt;
            if (start_ok) begin
                tag_q    <= start_tag_i;
                pushed_q <= 1'b0;
            end else if (done_o) begin
                pushed_q <= 1'b1;
            end
        end
    end

    // Word storage; contents are qualified by valid_q, so no reset is needed.
    always_ff @(posedge clk) begin
        if (we_ok) begin
            words_q[word_idx_i] <= word_i;
        end
    end

    assign probe_hit_o  = en_i && (tag_q == probe_tag_i) && valid_q[probe_idx_i];
    assign probe_word_o = words_q[probe_idx_i];
    assign done_o       = en_i && (&valid_q) && !pushed_q;
    assign line_tag_o   = tag_q;

    for (genvar w = 0; w < LINE_WORDS; w++) begin : g_line
        assign line_o[w*WORD_W +: WORD_W] = words_q[w];
    end

endmodule

// File: rtl/lfb_route.sv
// Picks the buffer that answers a fetch and the buffer that drives the
// write-back port. Assumes side 1 is instruction, side 0 is data; only one
// buffer can complete per cycle because words arrive one at a time.
module lfb_route #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned TAG_W  = 28,
    parameter int unsigned LINE_W = 128
) (
    input  logic                  fetch_valid_i,
    input  logic                  fetch_instr_i,
    input  logic                  arr_hit_i,
    input  logic [1:0]            hit_vec_i,
    input  logic [1:0][WORD_W-1:0] word_vec_i,
    input  logic [1:0]            done_vec_i,
    input  logic [1:0][TAG_W-1:0] tag_vec_i,
    input  logic [1:0][LINE_W-1:0] line_vec_i,
    output logic                  hit_o,
    output logic [WORD_W-1:0]     hit_data_o,
    output logic                  wb_valid_o,
    output logic                  wb_instr_o,
    output logic [TAG_W-1:0]      wb_tag_o,
    output logic [LINE_W-1:0]     wb_line_o
);

    // Fetch answer: the buffer of the fetch type, yielding to an array hit.
    always_comb begin
        hit_o      = fetch_valid_i && !arr_hit_i && hit_vec_i[fetch_instr_i];
        hit_data_o = word_vec_i[fetch_instr_i];
    end

    // Write-back source: instruction side first, then data side.
    always_comb begin
        wb_instr_o = done_vec_i[1];
        wb_valid_o = |done_vec_i;
        wb_tag_o   = tag_vec_i[wb_instr_o];
        wb_line_o  = line_vec_i[wb_instr_o];
    end

endmodule

// File: rtl/lfb_pair.sv
// Instruction and data line-fill buffers with per-word valids.
// Assumes at most one fill word per cycle (shared bus) and that the cache
// array reports its own hit on arr_hit_i for the same fetch.
module lfb_pair
    import lfb_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned WORD_W     = 32,
    parameter int unsigned LINE_WORDS = 4,
    localparam int unsigned BYTE_OFF  = $clog2(WORD_W / 8),
    localparam int unsigned IDX_W     = $clog2(LINE_WORDS),
    localparam int unsigned LINE_OFF  = BYTE_OFF + IDX_W,
    localparam int unsigned TAG_W     = ADDR_W - LINE_OFF,
    localparam int unsigned LINE_W    = WORD_W * LINE_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic              miss_start_i,
    input  logic              miss_instr_i,
    input  logic [ADDR_W-1:0] miss_addr_i,
    input  logic              fill_valid_i,
    input  logic              fill_instr_i,
    input  logic [ADDR_W-1:0] fill_addr_i,
    input  logic [WORD_W-1:0] fill_data_i,
    input  logic              fetch_valid_i,
    input  logic              fetch_instr_i,
    input  logic [ADDR_W-1:0] fetch_addr_i,
    input  logic              arr_hit_i,
    output logic              hit_o,
    output logic [WORD_W-1:0] hit_data_o,
    output logic              wb_valid_o,
    output logic              wb_instr_o,
    output logic [TAG_W-1:0]  wb_tag_o,
    output logic [LINE_W-1:0] wb_line_o
);

    logic [SIDES-1:0]             hit_vec;
    logic [SIDES-1:0][WORD_W-1:0] word_vec;
    logic [SIDES-1:0]             done_vec;
    logic [SIDES-1:0][TAG_W-1:0]  tag_vec;
    logic [SIDES-1:0][LINE_W-1:0] line_vec;
    logic                         unused_bits;

    // Address bits that take no part in line or word selection.
    assign unused_bits = ^{miss_addr_i[LINE_OFF-1:0], fill_addr_i[ADDR_W-1:LINE_OFF],
                           fill_addr_i[BYTE_OFF-1:0], fetch_addr_i[BYTE_OFF-1:0]};

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        localparam logic IS_INSTR = (s == SIDE_INSTR);
        logic en;
        logic start;
        logic we;

        // Side enable and side-select of the miss and fill strobes.
        always_comb begin
            en    = side_in_use(mode_i, IS_INSTR);
            start = miss_start_i && (miss_instr_i == IS_INSTR);
            we    = fill_valid_i && (fill_instr_i == IS_INSTR);
        end

        lfb_entry #(
            .WORD_W     (WORD_W),
            .LINE_WORDS (LINE_WORDS),
            .TAG_W      (TAG_W)
        ) u_entry (
            .clk          (clk),
            .rst_n        (rst_n),
            .en_i         (en),
            .start_i      (start),
            .start_tag_i  (miss_addr_i[ADDR_W-1:LINE_OFF]),
            .word_we_i    (we),
            .word_idx_i   (fill_addr_i[LINE_OFF-1:BYTE_OFF]),
            .word_i       (fill_data_i),
            .probe_tag_i  (fetch_addr_i[ADDR_W-1:LINE_OFF]),
            .probe_idx_i  (fetch_addr_i[LINE_OFF-1:BYTE_OFF]),
            .probe_hit_o  (hit_vec[s]),
            .probe_word_o (word_vec[s]),
            .done_o       (done_vec[s]),
            .line_tag_o   (tag_vec[s]),
            .line_o       (line_vec[s])
        );
    end

    lfb_route #(
        .WORD_W (WORD_W),
        .TAG_W  (TAG_W),
        .LINE_W (LINE_W)
    ) u_route (
        .fetch_valid_i (fetch_valid_i),
        .fetch_instr_i (fetch_instr_i),
        .arr_hit_i     (arr_hit_i),
        .hit_vec_i     (hit_vec),
        .word_vec_i    (word_vec),
        .done_vec_i    (done_vec),
        .tag_vec_i     (tag_vec),
        .line_vec_i    (line_vec),
        .hit_o         (hit_o),
        .hit_data_o    (hit_data_o),
        .wb_valid_o    (wb_valid_o),
        .wb_instr_o    (wb_instr_o),
        .wb_tag_o      (wb_tag_o),
        .wb_line_o     (wb_line_o)
    );

endmodule

// File: rtl/lfb_pair_chk.sv
// Port-level temporal checks for lfb_pair, attached by bind.
// Assumes reset is synchronous and active low.
module lfb_pair_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_i,
    input logic       miss_start_i,
    input logic       miss_instr_i,
    input logic       fill_valid_i,
    input logic       fill_instr_i,
    input logic       fetch_valid_i,
    input logic       fetch_instr_i,
    input logic       arr_hit_i,
    input logic       hit_o,
    input logic       wb_valid_o,
    input logic       wb_instr_o
);

    // R5
    arr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_hit_i |-> !hit_o);

    // R4
    hit_needs_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid_i |-> !hit_o);

    // R6
    instr_mode_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b00) |-> !(hit_o && !fetch_instr_i));

    // R6
    data_mode_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b01) |-> !(hit_o && fetch_instr_i));

    // R7
    wb_pulse_instr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid_o && wb_instr_o) |=> !(wb_valid_o && wb_instr_o));

    // R7
    wb_pulse_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid_o && !wb_instr_o) |=> !(wb_valid_o && !wb_instr_o));

    // R2
    miss_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_start_i && miss_instr_i && (mode_i != 2'b01)
         && !(fill_valid_i && fill_instr_i))
        |=> !(hit_o && fetch_instr_i));

endmodule

bind lfb_pair lfb_pair_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_i        (mode_i),
    .miss_start_i  (miss_start_i),
    .miss_instr_i  (miss_instr_i),
    .fill_valid_i  (fill_valid_i),
    .fill_instr_i  (fill_instr_i),
    .fetch_valid_i (fetch_valid_i),
    .fetch_instr_i (fetch_instr_i),
    .arr_hit_i     (arr_hit_i),
    .hit_o         (hit_o),
    .wb_valid_o    (wb_valid_o),
    .wb_instr_o    (wb_instr_o)
);

// File: tb/lfb_pair_tb.sv
// Self-checking bench for lfb_pair: a probe table walked by one loop, then
// directed tests for reset, partial lines, miss timing, modes and write-back.
module lfb_pair_tb;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   mode_i = 2'b10;
    logic         miss_start_i = 1'b0;
    logic         miss_instr_i = 1'b0;
    logic [31:0]  miss_addr_i = '0;
    logic         fill_valid_i = 1'b0;
    logic         fill_instr_i = 1'b0;
    logic [31:0]  fill_addr_i = '0;
    logic [31:0]  fill_data_i = '0;
    logic         fetch_valid_i = 1'b0;
    logic         fetch_instr_i = 1'b0;
    logic [31:0]  fetch_addr_i = '0;
    logic         arr_hit_i = 1'b0;
    logic         hit_o;
    logic [31:0]  hit_data_o;
    logic         wb_valid_o;
    logic         wb_instr_o;
    logic [27:0]  wb_tag_o;
    logic [127:0] wb_line_o;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lfb_pair u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_i        (mode_i),
        .miss_start_i  (miss_start_i),
        .miss_instr_i  (miss_instr_i),
        .miss_addr_i   (miss_addr_i),
        .fill_valid_i  (fill_valid_i),
        .fill_instr_i  (fill_instr_i),
        .fill_addr_i   (fill_addr_i),
        .fill_data_i   (fill_data_i),
        .fetch_valid_i (fetch_valid_i),
        .fetch_instr_i (fetch_instr_i),
        .fetch_addr_i  (fetch_addr_i),
        .arr_hit_i     (arr_hit_i),
        .hit_o         (hit_o),
        .hit_data_o    (hit_data_o),
        .wb_valid_o    (wb_valid_o),
        .wb_instr_o    (wb_instr_o),
        .wb_tag_o      (wb_tag_o),
        .wb_line_o     (wb_line_o)
    );

    // Probe table: {instr, addr, arr_hit, exp_hit, exp_data}.
    localparam int NVEC = 10;
    localparam logic [66:0] VEC [NVEC] = '{
        {1'b1, 32'h0000_1230, 1'b0, 1'b1, 32'hC0DE_0000},
        {1'b1, 32'h0000_123C, 1'b0, 1'b1, 32'hC0DE_0003},
        {1'b1, 32'h0000_1233, 1'b0, 1'b1, 32'hC0DE_0000},
        {1'b1, 32'h0000_1238, 1'b1, 1'b0, 32'h0},
        {1'b1, 32'h0000_1240, 1'b0, 1'b0, 32'h0},
        {1'b0, 32'h0000_4564, 1'b0, 1'b1, 32'hDA7A_0001},
        {1'b0, 32'h0000_4560, 1'b0, 1'b0, 32'h0},
        {1'b0, 32'h0000_456C, 1'b0, 1'b1, 32'hDA7A_0003},
        {1'b0, 32'h0000_1230, 1'b0, 1'b0, 32'h0},
        {1'b1, 32'h0000_4564, 1'b0, 1'b0, 32'h0}
    };

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic miss(input logic instr, input logic [31:0] addr);
        @(negedge clk);
        miss_start_i = 1'b1; miss_instr_i = instr; miss_addr_i = addr;
        tick();
        miss_start_i = 1'b0;
    endtask

    task automatic fill(input logic instr, input logic [31:0] addr, input logic [31:0] data);
        @(negedge clk);
        fill_valid_i = 1'b1; fill_instr_i = instr; fill_addr_i = addr; fill_data_i = data;
        tick();
        fill_valid_i = 1'b0;
    endtask

    // Present a fetch away from the edge and compare hit and, on a hit, the data.
    task automatic probe(input string req, input logic instr, input logic [31:0] addr,
                         input logic arr, input logic exp_hit, input logic [31:0] exp_data);
        @(negedge clk);
        fetch_valid_i = 1'b1; fetch_instr_i = instr; fetch_addr_i = addr; arr_hit_i = arr;
        #1;
        chk(req, hit_o, exp_hit);
        if (exp_hit) chk(req, hit_data_o, exp_data);
        fetch_valid_i = 1'b0; arr_hit_i = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        probe("R1", 1'b1, 32'h0, 1'b0, 1'b0, 32'h0);
        probe("R1", 1'b0, 32'h0, 1'b0, 1'b0, 32'h0);
        chk("R1", wb_valid_o, 1'b0);

        // Setup: full instruction line, partial data line (split mode).
        mode_i = 2'b10;
        miss(1'b1, 32'h0000_1234);
        for (int k = 0; k < 3; k++) begin
            fill(1'b1, 32'h0000_1230 + 32'(4*k), 32'hC0DE_0000 + 32'(k));
            chk("R7", wb_valid_o, 1'b0);
        end
        fill(1'b1, 32'h0000_123C, 32'hC0DE_0003);
        // R7: pulse with type, tag and word layout
        chk("R7", wb_valid_o, 1'b1);
        chk("R7", wb_instr_o, 1'b1);
        chk("R7", wb_tag_o, 28'h0000123);
        chk("R7", wb_line_o, {32'hC0DE_0003, 32'hC0DE_0002, 32'hC0DE_0001, 32'hC0DE_0000});
        tick();
        chk("R7", wb_valid_o, 1'b0);
        miss(1'b0, 32'h0000_4560);
        fill(1'b0, 32'h0000_4564, 32'hDA7A_0001);
        fill(1'b0, 32'h0000_456C, 32'hDA7A_0003);
        chk("R7", wb_valid_o, 1'b0);

        // Table walk (R3, R4, R5, R6)
        for (int i = 0; i < NVEC; i++) begin
            probe("R4", VEC[i][66], VEC[i][65:34], VEC[i][33], VEC[i][32], VEC[i][31:0]);
        end

        // R3: word usable only after its capture edge, other words still absent
        miss(1'b1, 32'h0000_8880);
        @(negedge clk);
        fill_valid_i = 1'b1; fill_instr_i = 1'b1; fill_addr_i = 32'h0000_8888;
        fill_data_i = 32'h5555_0002;
        fetch_valid_i = 1'b1; fetch_instr_i = 1'b1; fetch_addr_i = 32'h0000_8888;
        #1;
        chk("R3", hit_o, 1'b0);
        tick();
        fill_valid_i = 1'b0;
        chk("R3", hit_o, 1'b1);
        chk("R3", hit_data_o, 32'h5555_0002);
        fetch_valid_i = 1'b0;
        probe("R3", 1'b1, 32'h0000_8884, 1'b0, 1'b0, 32'h0);
        // R2: old instruction line gone after the new miss
        probe("R2", 1'b1, 32'h0000_1230, 1'b0, 1'b0, 32'h0);

        // R2: repeating the miss clears the word just filled
        miss(1'b1, 32'h0000_8880);
        probe("R2", 1'b1, 32'h0000_8888, 1'b0, 1'b0, 32'h0);

        // R8: miss and word in the same cycle
        @(negedge clk);
        miss_start_i = 1'b1; miss_instr_i = 1'b0; miss_addr_i = 32'h0000_9990;
        fill_valid_i = 1'b1; fill_instr_i = 1'b0; fill_addr_i = 32'h0000_9990;
        fill_data_i = 32'h7777_0000;
        tick();
        miss_start_i = 1'b0; fill_valid_i = 1'b0;
        probe("R8", 1'b0, 32'h0000_9990, 1'b0, 1'b1, 32'h7777_0000);

        // R6: data buffer out of use ignores fetch, miss and fill
        mode_i = 2'b00;
        probe("R6", 1'b0, 32'h0000_9990, 1'b0, 1'b0, 32'h0);
        fill(1'b0, 32'h0000_9994, 32'h7777_0001);
        miss(1'b0, 32'h0000_AAA0);
        mode_i = 2'b11;
        probe("R6", 1'b0, 32'h0000_9990, 1'b0, 1'b1, 32'h7777_0000);
        probe("R6", 1'b0, 32'h0000_9994, 1'b0, 1'b0, 32'h0);
        mode_i = 2'b01;
        probe("R6", 1'b1, 32'h0000_1230, 1'b0, 1'b0, 32'h0);
        mode_i = 2'b10;

        // R9 and R7: out-of-order fill, single pulse, line retained
        miss(1'b1, 32'h0000_8880);
        fill(1'b1, 32'h0000_888C, 32'hBEEF_0003);
        fill(1'b1, 32'h0000_8884, 32'hBEEF_0001);
        fill(1'b1, 32'h0000_8880, 32'hBEEF_0000);
        chk("R7", wb_valid_o, 1'b0);
        fill(1'b1, 32'h0000_8888, 32'hBEEF_0002);
        chk("R7", wb_valid_o, 1'b1);
        chk("R7", wb_line_o, {32'hBEEF_0003, 32'hBEEF_0002, 32'hBEEF_0001, 32'hBEEF_0000});
        tick();
        chk("R7", wb_valid_o, 1'b0);
        repeat (3) tick();
        chk("R9", wb_valid_o, 1'b0);
        probe("R9", 1'b1, 32'h0000_8884, 1'b0, 1'b1, 32'hBEEF_0001);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule